// File: doc/BRIEF.md
# Triple Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters that share one clock and sit behind a simple single-cycle register bus. Each channel can advance on every clock or on a tick from its own power-of-two divider. It can run free, wrapping past its top value, or run in interval mode, returning to zero when it reaches a programmed limit. Each channel drives its own interrupt line.

Software configures a channel through six register types. Registers of one type sit together, and the three channels of that type follow each other at a 4-byte stride. Pending flags are acknowledged by reading them. A restart command zeroes a channel's count without stopping it, which is how a one-shot or periodic interval is re-armed.

Top module: `tri_timer_ctr`

## Requirements
- R1: After reset every count is 0, every counter is held (counter control reads 0x1), the prescaler is off (clock control reads 0x0), the interval reads 0xFFFF, status and enables read 0, and every irq line is low.
- R2: A running channel with prescaler off adds 1 to its count on every clock. Leaving 0xFFFF it wraps to 0 and sets status bit 1 (wrap flag).
- R3: While counter control bit 0 (hold) is set, the count keeps its value.
- R4: Writing counter control with bit 4 set forces the count to 0 on that clock edge, whatever the hold bit and mode. The divider phase is also reset. The bit is not stored and reads back as 0. Bit 0 and bit 1 of the same write take effect, and bit 5 and all other bits are ignored.
- R5: Clock control bit 0 enables the prescaler, and bits 4:1 hold N. When enabled, the count advances once every 2^(N+1) clocks, counted from the last restart or clock-control write.
- R6: With counter control bit 1 (interval mode) set, a count step taken while the count equals the interval value loads 0 instead and sets status bit 0. That step does not set the wrap flag.
- R7: A read of a channel's status returns its flags and clears them. A flag set by an event on the same clock survives the read. No flag clears in any other way.
- R8: A channel's irq is high exactly when one of its status bits is set together with the matching enable bit (enable bit 0 for the interval flag, bit 1 for the wrap flag).
- R9: Channel c uses byte addresses 0x00+4c (clock control), 0x0C+4c (counter control), 0x18+4c (count, read-only), 0x24+4c (interval), 0x54+4c (status, read-only), 0x60+4c (interrupt enable). Writes to read-only or unmapped addresses change nothing. Unmapped or misaligned reads return 0.
- R10: Read data appears on the clock edge that samples the read strobe. It holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels and the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt, bit c for channel c |

## Verification
A wrong count or divider phase shows on the next read of the count register. Because the bench reads back every few cycles against a cycle-exact model, a one-step slip is reported within a few clocks. A wrongly cleared or lost flag shows at once on the irq line of an enabled channel, and on the next status read otherwise. A decode fault shows on the first access to the misrouted register, through the value read back or through a count that should not have moved. The wrap path is slow to reach, so a dedicated run of 65,536 steps covers it.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

   // register kinds; K_NONE marks an unmapped access
   typedef enum logic [2:0] {
      K_CLK  = 3'd0,
      K_CTL  = 3'd1,
      K_CNT  = 3'd2,
      K_IVL  = 3'd3,
      K_STAT = 3'd4,
      K_IEN  = 3'd5,
      K_NONE = 3'd7
   } reg_kind_e;

   localparam int NUM_KINDS = 6;
   localparam int STRIDE    = 4;

   // status / enable bit positions
   localparam int ST_W    = 2;
   localparam int ST_IVL  = 0;
   localparam int ST_WRAP = 1;

   // clock control fields
   localparam int CK_PEN     = 0;
   localparam int CK_EXP_LSB = 1;

   // counter control fields
   localparam int CT_HOLD    = 0;
   localparam int CT_IMODE   = 1;
   localparam int CT_RESTART = 4;

   typedef struct packed {
      logic       hit;
      reg_kind_e  kind;
      logic [1:0] ch;
   } dec_t;

   function automatic int kind_base(int k);
      case (k)
         0:       return 'h00;
         1:       return 'h0C;
         2:       return 'h18;
         3:       return 'h24;
         4:       return 'h54;
         5:       return 'h60;
         default: return 'h100;
      endcase
   endfunction

endpackage

// File: rtl/ttc_addr_dec.sv
module ttc_addr_dec
   import ttc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NUM_CH = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int SPAN = STRIDE * NUM_CH;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ttc_addr_dec: ADDR_W must cover 0x6B");
      end
   endgenerate

   always_comb begin
      dec.hit  = 1'b0;
      dec.kind = K_NONE;
      dec.ch   = 2'd0;
      for (int k = 0; k < NUM_KINDS; k++) begin
         int off;
         off = int'(addr) - kind_base(k);
         if (off >= 0 && off < SPAN && (off % STRIDE) == 0) begin
            dec.hit  = 1'b1;
            dec.kind = reg_kind_e'(3'(k));
            dec.ch   = 2'(off / STRIDE);
         end
      end
   end

endmodule

// File: rtl/ttc_prescaler.sv
module ttc_prescaler #(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pre_en,
   input  logic [EXP_W-1:0] expo,
   input  logic             clr,
   output logic             tick
);

   localparam int DIV_W = (1 << EXP_W) + 1;

   generate
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("ttc_prescaler: EXP_W must be 1..5");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic [EXP_W:0]   shamt;

   always_comb begin
      shamt = {1'b0, expo} + 1'b1;
      mask  = ({{(DIV_W-1){1'b0}}, 1'b1} << shamt) - 1'b1;
      tick  = run && (!pre_en || ((div_q & mask) == mask));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     div_q <= '0;
      else if (clr || !run || !pre_en) div_q <= '0;
      else                            div_q <= div_q + 1'b1;
   end

endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
   import ttc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int EXP_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_clk,
   input  logic              wr_ctl,
   input  logic              wr_ivl,
   input  logic              wr_ien,
   input  logic              rd_stat,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  ivl_o,
   output logic              pen_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic              hold_o,
   output logic              imode_o,
   output logic [ST_W-1:0]   stat_o,
   output logic [ST_W-1:0]   ien_o,
   output logic              tick_o,
   output logic              restart_o,
   output logic              irq_o
);

   logic [CNT_W-1:0] cnt_q, ivl_q;
   logic             pen_q, hold_q, imode_q;
   logic [EXP_W-1:0] exp_q;
   logic [ST_W-1:0]  stat_q, ien_q, ev_set;
   logic             tick, restart, at_limit;

   assign restart  = wr_ctl && wdata[CT_RESTART];
   assign at_limit = imode_q && (cnt_q == ivl_q);

   ttc_prescaler #(.EXP_W(EXP_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (!hold_q),
      .pre_en (pen_q),
      .expo   (exp_q),
      .clr    (restart || wr_clk),
      .tick   (tick)
   );

   // events raised by a count step
   always_comb begin
      ev_set          = '0;
      ev_set[ST_IVL]  = tick && !restart && at_limit;
      ev_set[ST_WRAP] = tick && !restart && !at_limit && (&cnt_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (at_limit) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pen_q   <= 1'b0;
         exp_q   <= '0;
         hold_q  <= 1'b1;
         imode_q <= 1'b0;
         ivl_q   <= '1;
         ien_q   <= '0;
      end else begin
         if (wr_clk) begin
            pen_q <= wdata[CK_PEN];
            exp_q <= wdata[CK_EXP_LSB +: EXP_W];
         end
         if (wr_ctl) begin
            hold_q  <= wdata[CT_HOLD];
            imode_q <= wdata[CT_IMODE];
         end
         if (wr_ivl) ivl_q <= wdata[CNT_W-1:0];
         if (wr_ien) ien_q <= wdata[ST_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (rd_stat ? '0 : stat_q) | ev_set;
   end

   assign cnt_o     = cnt_q;
   assign ivl_o     = ivl_q;
   assign pen_o     = pen_q;
   assign exp_o     = exp_q;
   assign hold_o    = hold_q;
   assign imode_o   = imode_q;
   assign stat_o    = stat_q;
   assign ien_o     = ien_q;
   assign tick_o    = tick;
   assign restart_o = restart;
   assign irq_o     = |(stat_q & ien_q);

endmodule

// File: rtl/tri_timer_ctr.sv
module tri_timer_ctr
   import ttc_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int EXP_W  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   generate
      if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
         $error("tri_timer_ctr: NUM_CH must be 1..3");
      end
      if (DATA_W < CNT_W || DATA_W < EXP_W + 1) begin : g_bad_data
         $error("tri_timer_ctr: DATA_W too narrow");
      end
   endgenerate

   dec_t dec;

   logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec, ivl_vec;
   logic [NUM_CH-1:0][EXP_W-1:0] exp_vec;
   logic [NUM_CH-1:0][ST_W-1:0]  stat_vec, ien_vec;
   logic [NUM_CH-1:0]            pen_vec, hold_vec, imode_vec;
   logic [NUM_CH-1:0]            tick_vec, restart_vec, stat_clr_vec;

   ttc_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = dec.hit && (dec.ch == 2'(c));
      assign stat_clr_vec[c] = bus_re && sel && (dec.kind == K_STAT);

      ttc_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W), .DATA_W(DATA_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_clk    (bus_we && sel && (dec.kind == K_CLK)),
         .wr_ctl    (bus_we && sel && (dec.kind == K_CTL)),
         .wr_ivl    (bus_we && sel && (dec.kind == K_IVL)),
         .wr_ien    (bus_we && sel && (dec.kind == K_IEN)),
         .rd_stat   (stat_clr_vec[c]),
         .wdata     (bus_wdata),
         .cnt_o     (cnt_vec[c]),
         .ivl_o     (ivl_vec[c]),
         .pen_o     (pen_vec[c]),
         .exp_o     (exp_vec[c]),
         .hold_o    (hold_vec[c]),
         .imode_o   (imode_vec[c]),
         .stat_o    (stat_vec[c]),
         .ien_o     (ien_vec[c]),
         .tick_o    (tick_vec[c]),
         .restart_o (restart_vec[c]),
         .irq_o     (irq[c])
      );
   end

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (dec.hit) begin
         case (dec.kind)
            K_CLK: begin
               rd_val[CK_PEN]                = pen_vec[dec.ch];
               rd_val[CK_EXP_LSB +: EXP_W]   = exp_vec[dec.ch];
            end
            K_CTL: begin
               rd_val[CT_HOLD]  = hold_vec[dec.ch];
               rd_val[CT_IMODE] = imode_vec[dec.ch];
            end
            K_CNT:   rd_val[CNT_W-1:0] = cnt_vec[dec.ch];
            K_IVL:   rd_val[CNT_W-1:0] = ivl_vec[dec.ch];
            K_STAT:  rd_val[ST_W-1:0]  = stat_vec[dec.ch];
            K_IEN:   rd_val[ST_W-1:0]  = ien_vec[dec.ch];
            default: rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_val;
   end

endmodule

// File: rtl/tri_timer_ctr_chk.sv
module tri_timer_ctr_chk
   import ttc_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_re,
   input logic [DATA_W-1:0]            bus_rdata,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec,
   input logic [NUM_CH-1:0][CNT_W-1:0] ivl_vec,
   input logic [NUM_CH-1:0]            hold_vec,
   input logic [NUM_CH-1:0]            imode_vec,
   input logic [NUM_CH-1:0]            tick_vec,
   input logic [NUM_CH-1:0]            restart_vec,
   input logic [NUM_CH-1:0][ST_W-1:0]  stat_vec,
   input logic [NUM_CH-1:0]            stat_clr_vec
);

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R2
      step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick_vec[c] && !restart_vec[c] && !imode_vec[c]
         |=> cnt_vec[c] == CNT_W'($past(cnt_vec[c]) + 1'b1));

      // R3
      hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hold_vec[c] && !restart_vec[c] |=> $stable(cnt_vec[c]));

      // R4
      restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         restart_vec[c] |=> cnt_vec[c] == '0);

      // R5
      no_tick_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tick_vec[c] && !restart_vec[c] |=> $stable(cnt_vec[c]));

      // R6
      limit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick_vec[c] && !restart_vec[c] && imode_vec[c] && cnt_vec[c] == ivl_vec[c]
         |=> cnt_vec[c] == '0 && stat_vec[c][ST_IVL]);

      for (genvar b = 0; b < ST_W; b++) begin : g_b
         // R7
         flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stat_vec[c][b] && !stat_clr_vec[c] |=> stat_vec[c][b]);
      end
   end

endmodule

bind tri_timer_ctr tri_timer_ctr_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_re       (bus_re),
   .bus_rdata    (bus_rdata),
   .cnt_vec      (cnt_vec),
   .ivl_vec      (ivl_vec),
   .hold_vec     (hold_vec),
   .imode_vec    (imode_vec),
   .tick_vec     (tick_vec),
   .restart_vec  (restart_vec),
   .stat_vec     (stat_vec),
   .stat_clr_vec (stat_clr_vec)
);

// File: tb/tri_timer_ctr_bench.sv
`timescale 1ns/1ps
module tri_timer_ctr_bench;

   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   tri_timer_ctr u_tri_timer_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // ---------------- reference model ----------------
   int m_pen[NCH], m_exp[NCH], m_hold[NCH], m_imode[NCH];
   int m_cnt[NCH], m_ivl[NCH], m_st[NCH], m_ie[NCH], m_div[NCH];
   int m_rdata;

   function automatic int base_of(int k);
      case (k)
         0: return 'h00;  1: return 'h0C;  2: return 'h18;
         3: return 'h24;  4: return 'h54;  default: return 'h60;
      endcase
   endfunction

   function automatic int model_read(int a);
      for (int k = 0; k < 6; k++) begin
         for (int c = 0; c < NCH; c++) begin
            if (a == base_of(k) + 4*c) begin
               case (k)
                  0: return m_pen[c] | (m_exp[c] << 1);
                  1: return m_hold[c] | (m_imode[c] << 1);
                  2: return m_cnt[c];
                  3: return m_ivl[c];
                  4: return m_st[c];
                  default: return m_ie[c];
               endcase
            end
         end
      end
      return 0;
   endfunction

   function automatic int model_irq();
      int v = 0;
      for (int c = 0; c < NCH; c++)
         if ((m_st[c] & m_ie[c]) != 0) v |= (1 << c);
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_pen[c] = 0; m_exp[c] = 0; m_hold[c] = 1; m_imode[c] = 0;
            m_cnt[c] = 0; m_ivl[c] = 'hFFFF; m_st[c] = 0; m_ie[c] = 0; m_div[c] = 0;
         end
         m_rdata = 0;
      end else begin
         int a, wd;
         a  = int'(bus_addr);
         wd = int'(bus_wdata);
         if (bus_re) m_rdata = model_read(a);
         for (int c = 0; c < NCH; c++) begin
            int mask, tick, rs, wclk, ev;
            mask = (1 << (m_exp[c] + 1)) - 1;
            tick = (m_hold[c] == 0) && (m_pen[c] == 0 || (m_div[c] & mask) == mask);
            rs   = bus_we && a == 'h0C + 4*c && wd[4];
            wclk = bus_we && a == 'h00 + 4*c;
            ev   = 0;
            m_div[c] = (rs || wclk || m_hold[c] || !m_pen[c]) ? 0 : ((m_div[c] + 1) & 'h1FFFF);
            if (rs) m_cnt[c] = 0;
            else if (tick) begin
               if (m_imode[c] && m_cnt[c] == m_ivl[c]) begin
                  m_cnt[c] = 0; ev = 1;
               end else begin
                  if (m_cnt[c] == 'hFFFF) ev = 2;
                  m_cnt[c] = (m_cnt[c] + 1) & 'hFFFF;
               end
            end
            m_st[c] = ((bus_re && a == 'h54 + 4*c) ? 0 : m_st[c]) | ev;
            if (wclk) begin m_pen[c] = wd & 1; m_exp[c] = (wd >> 1) & 'hF; end
            if (bus_we && a == 'h0C + 4*c) begin m_hold[c] = wd & 1; m_imode[c] = (wd >> 1) & 1; end
            if (bus_we && a == 'h24 + 4*c) m_ivl[c] = wd & 'hFFFF;
            if (bus_we && a == 'h60 + 4*c) m_ie[c] = wd & 3;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic do_write(int a, int d);
      bus_addr = 8'(a); bus_wdata = 32'(d); bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic do_read(int a, string tag, output int val);
      bus_addr = 8'(a); bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      val = int'(bus_rdata);
      check(tag, val, m_rdata);
      check({tag, " irq"}, {29'd0, irq}, model_irq());
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int v;
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      do_read('h18, "R1 count", v);    check("R1 count literal", v, 0);
      do_read('h10, "R1 ctl", v);      check("R1 ctl literal", v, 1);
      do_read('h04, "R1 clk", v);      check("R1 clk literal", v, 0);
      do_read('h2C, "R1 ivl", v);      check("R1 ivl literal", v, 'hFFFF);
      check("R1 irq literal", {29'd0, irq}, 0);

      // R9 read-only and unmapped accesses
      do_write('h1C, 'h1234);
      do_read('h1C, "R9 ro count", v); check("R9 ro count literal", v, 0);
      do_write('h58, 'h3);
      do_read('h58, "R9 ro stat", v);  check("R9 ro stat literal", v, 0);
      do_read('h30, "R9 unmapped", v); check("R9 unmapped literal", v, 0);
      do_read('h02, "R9 misaligned", v); check("R9 misaligned literal", v, 0);

      // R2 / R4 free run then restart
      do_write('h0C, 'h10);
      idle(20);
      do_read('h18, "R2 freerun", v);
      do_write('h0C, 'h10);
      do_read('h0C, "R4 selfclear", v); check("R4 selfclear literal", v, 0);
      do_read('h18, "R4 restart", v);

      // R3 hold with restart
      do_write('h10, 'h11);
      idle(10);
      do_read('h1C, "R3 hold", v);     check("R3 hold literal", v, 0);

      // R6/R7/R8 interval 0: event every clock, flag survives read
      do_write('h64, 'h1);
      do_write('h28, 'h0);
      do_write('h10, 'h12);
      idle(3);
      do_read('h58, "R7 stat", v);     check("R7 stat literal", v, 1);
      do_read('h58, "R7 same-cycle keep", v); check("R7 keep literal", v, 1);
      check("R8 irq1 literal", int'(irq[1]), 1);
      do_write('h10, 'h11);
      do_read('h58, "R7 clear1", v);
      do_read('h58, "R7 clear2", v);   check("R7 cleared literal", v, 0);
      check("R8 irq1 low literal", int'(irq[1]), 0);

      // R5 prescaler on channel 2
      do_write('h08, 'h1 | (2 << 1));
      do_write('h14, 'h10);
      for (int i = 0; i < 12; i++) begin
         idle(3);
         do_read('h20, "R5 prescaled", v);
      end

      // R2 wrap on channel 0, enable wrap interrupt
      do_write('h60, 'h2);
      do_write('h0C, 'h10);
      idle(65540);
      check("R8 wrap irq literal", int'(irq[0]), 1);
      do_read('h54, "R2 wrap stat", v); check("R2 wrap literal", v, 2);

      // constrained random phase
      for (int it = 0; it < 3000; it++) begin
         int ch, op;
         ch = $urandom_range(0, 2);
         op = $urandom_range(0, 9);
         case (op)
            0: do_write('h00 + 4*ch, ($urandom_range(0, 1)) | ($urandom_range(0, 2) << 1));
            1: do_write('h0C + 4*ch, ($urandom_range(0, 3) == 0 ? 1 : 0) | ($urandom_range(0, 1) << 1)
                                     | ($urandom_range(0, 1) << 4) | ($urandom_range(0, 1) << 5));
            2: do_write('h24 + 4*ch, $urandom_range(0, 3) == 0 ? int'($urandom_range(0, 'hFFFF))
                                                                : int'($urandom_range(0, 30)));
            3: do_write('h60 + 4*ch, $urandom_range(0, 3));
            4: do_write(($urandom_range(0, 1) ? 'h18 : 'h54) + 4*ch, int'($urandom()));
            5: do_read('h54 + 4*ch, "R7 rand stat", v);
            6: do_read('h18 + 4*ch, "R6 rand count", v);
            7: do_read(base_of($urandom_range(0, 5)) + 4*ch, "R9 rand reg", v);
            8: do_read($urandom_range(0, 255), "R10 rand addr", v);
            default: idle($urandom_range(1, 6));
         endcase
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule